// File: doc/BRIEF.md
# External Bus Arbitration Controller

This block decides who owns a processor's shared external address and data bus. It uses three handshake lines: request, grant and busy. A mode input selects one of two roles. In slave mode the processor owns the bus by default and gives it up when another master asks for it. In master mode the processor must ask for the bus and wait for a grant before it starts any external access.

The core side presents an access request with two qualifiers: a program-or-data flag and a read-modify-write lock. The block runs each granted access through a fixed sequence of bus phases. It returns a stall signal that holds the core while the bus is not available. It also drives the output enables of the bus strobes, the busy line, and the direction controls of the request and grant pins.

All pins are active high. The request, grant and busy inputs pass through a synchronizer before the state machine uses them.

Top module: `busarb_ctrl`

## Requirements
- R1: Reset state. While reset is active:
  - the block is in slave home and owns the bus;
  - `busy_out`=1, every bit of `strobe_oe`=1, `gnt_out`=0, `req_out`=0 and `wait_st`=0;
  - `req_oe` equals `master_mode` (1 drives the request pin) and `gnt_oe` is its inverse.
- R2: The request, grant and busy inputs each pass through SYNC_STAGES flip-flops (default 2). With the block in slave mode, owning the bus, idle and not locked, a request input raised before an edge makes `gnt_out` rise on the third rising edge.
- R3: While the bus is released in slave mode, `gnt_out`=1, `busy_out`=0 and every bit of `strobe_oe`=0.
- R4: A release never cuts an access short. A request that arrives during an access is granted only after the last phase of that access, at the next cycle boundary.
- R5: While `core_rmw`=1, slave mode never releases the bus. The release is taken at the first boundary after `core_rmw` falls.
- R6: Once released, slave mode takes the bus back only after the synchronized request and busy inputs are both 0. On that edge `gnt_out` falls and `busy_out` rises.
- R7: An access lasts NUM_PHASES consecutive cycles:
  - `acc_active`=1 throughout, and `acc_phase` counts 0 to NUM_PHASES-1;
  - `acc_done`=1 only in the last phase;
  - `busy_out` and `strobe_oe` stay asserted throughout.
- R8: `wait_st`=1 in exactly those cycles in which `core_req`=1 and the next edge neither continues nor starts an access.
- R9: In master mode, a core request raises `req_out` at the next edge. The access starts (phase 0) at the first edge where the synchronized grant is 1 and the synchronized busy is 0. `req_out` stays high while the block waits.
- R10: In master mode, `busy_out` and `strobe_oe` are asserted only during access cycles.
- R11: In master mode, in the cycle after an access ends, `req_out` depends on the access type (`core_prog`=1 means program, 0 means data):
  - after a program access, `req_out` is 0 unless `req_hold` or `core_rmw` is 1;
  - after a data access, `req_out` is 1.
- R12: In master mode, `req_hold`=1 forces `req_out`=1 from the next edge. In slave mode, `req_out` is always 0.
- R13: In master mode, with grant held at 1 and busy at 0, `req_out` rises in the same cycle as phase 0 of the access, so it acts as a per-access chip select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| master_mode | input | 1 | 1 selects master mode, 0 selects slave mode |
| req_hold | input | 1 | Software hold of the request line in master mode |
| core_req | input | 1 | Core wants an external access; held until `acc_done` |
| core_prog | input | 1 | 1 = program access, 0 = data access |
| core_rmw | input | 1 | Read-modify-write lock |
| req_in | input | 1 | Request pin, input value |
| req_out | output | 1 | Request pin, driven value |
| req_oe | output | 1 | Request pin output enable |
| gnt_in | input | 1 | Grant pin, input value |
| gnt_out | output | 1 | Grant pin, driven value |
| gnt_oe | output | 1 | Grant pin output enable |
| busy_in | input | 1 | Busy line from other masters |
| busy_out | output | 1 | Busy asserted while this block owns the bus |
| strobe_oe | output | NUM_STROBES | Output enables of the bus strobes |
| wait_st | output | 1 | Stall to the core |
| acc_active | output | 1 | An access is in progress |
| acc_phase | output | PHASE_W | Current access phase |
| acc_done | output | 1 | Last phase of the access |

## Verification
The bench targets the following corner cases, each with the failure a wrong design would show:
- A request that lands mid-access: a design that arbitrates off a cycle boundary would raise grant before `acc_done`.
- A request held off by a read-modify-write lock: a design that ignores the lock would hand the bus away inside the sequence.
- A request withdrawn while busy stays high: a design that checks only the request would take the bus back while another master still drives it.
- In master mode, the bench compares the request level after program and data accesses. A design without the toggle rule would leave the request high between program accesses, or drop it between data accesses.
- With grant tied high, it checks that the request rises exactly in phase 0.
- With grant withheld, it checks that the access waits on the synchronized grant.

// File: rtl/busarb_pkg.sv
package busarb_pkg;
   // Arbitration states. OWN is slave home, IDLE is master home.
   typedef enum logic [2:0] {
      ARB_OWN  = 3'd0,
      ARB_REL  = 3'd1,
      ARB_IDLE = 3'd2,
      ARB_WAIT = 3'd3,
      ARB_ACC  = 3'd4
   } arb_state_e;
endpackage

// File: rtl/busarb_sync.sv
module busarb_sync #(
   parameter int WIDTH  = 3,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("busarb_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("busarb_sync: WIDTH must be at least 1");
   end

   logic [STAGES-1:0][WIDTH-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/busarb_phase.sv
module busarb_phase #(
   parameter  int NUM_PHASES = 4,
   localparam int PW         = (NUM_PHASES > 1) ? $clog2(NUM_PHASES) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   output logic [PW-1:0] phase,
   output logic          last
);
   if (NUM_PHASES < 2) begin : g_bad_phases
      $error("busarb_phase: NUM_PHASES must be at least 2");
   end

   localparam logic [PW-1:0] LAST_IDX = PW'(NUM_PHASES - 1);

   assign last = run && (phase == LAST_IDX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            phase <= '0;
      else if (!run || last) phase <= '0;
      else                   phase <= phase + 1'b1;
   end
endmodule

// File: rtl/busarb_ctrl.sv
module busarb_ctrl
   import busarb_pkg::*;
#(
   parameter  int NUM_PHASES  = 4,
   parameter  int SYNC_STAGES = 2,
   parameter  int NUM_STROBES = 5,
   localparam int PHASE_W     = (NUM_PHASES > 1) ? $clog2(NUM_PHASES) : 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   master_mode,
   input  logic                   req_hold,
   input  logic                   core_req,
   input  logic                   core_prog,
   input  logic                   core_rmw,
   input  logic                   req_in,
   output logic                   req_out,
   output logic                   req_oe,
   input  logic                   gnt_in,
   output logic                   gnt_out,
   output logic                   gnt_oe,
   input  logic                   busy_in,
   output logic                   busy_out,
   output logic [NUM_STROBES-1:0] strobe_oe,
   output logic                   wait_st,
   output logic                   acc_active,
   output logic [PHASE_W-1:0]     acc_phase,
   output logic                   acc_done
);
   if (NUM_STROBES < 1) begin : g_bad_strobes
      $error("busarb_ctrl: NUM_STROBES must be at least 1");
   end

   // ---------------- input synchronizer ----------------
   logic [2:0] pins_s;
   logic       br_s, bg_s, bb_s, bus_free;

   busarb_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({busy_in, gnt_in, req_in}),
      .q     (pins_s)
   );

   assign br_s     = pins_s[0];
   assign bg_s     = pins_s[1];
   assign bb_s     = pins_s[2];
   assign bus_free = bg_s && !bb_s;

   // ---------------- phase sequencer ----------------
   arb_state_e state, state_n;
   logic       last_ph;

   busarb_phase #(.NUM_PHASES(NUM_PHASES)) u_phase (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (state == ARB_ACC),
      .phase (acc_phase),
      .last  (last_ph)
   );

   // ---------------- arbitration state machine ----------------
   logic slave_yield;
   assign slave_yield = br_s && !core_rmw;

   always_comb begin
      state_n = state;
      unique case (state)
         ARB_OWN:  if (master_mode)        state_n = ARB_IDLE;
                   else if (slave_yield)   state_n = ARB_REL;
                   else if (core_req)      state_n = ARB_ACC;
         ARB_REL:  if (!br_s && !bb_s)     state_n = ARB_OWN;
         ARB_IDLE: if (!master_mode)       state_n = ARB_OWN;
                   else if (core_req)      state_n = bus_free ? ARB_ACC : ARB_WAIT;
         ARB_WAIT: if (!master_mode)       state_n = ARB_OWN;
                   else if (bus_free)      state_n = ARB_ACC;
         ARB_ACC:  if (last_ph)            state_n = master_mode ? ARB_IDLE : ARB_OWN;
         default:                          state_n = ARB_OWN;
      endcase
   end

   // Request pin level for the next cycle (master mode only).
   logic br_q, br_n, prog_q;

   always_comb begin
      if (!master_mode)            br_n = 1'b0;
      else if (state == ARB_ACC)   br_n = last_ph ? (req_hold || core_rmw || !prog_q) : 1'b1;
      else                         br_n = req_hold || core_rmw || core_req;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ARB_OWN;
         br_q   <= 1'b0;
         prog_q <= 1'b0;
      end else begin
         state <= state_n;
         br_q  <= br_n;
         if (state != ARB_ACC && state_n == ARB_ACC) prog_q <= core_prog;
      end
   end

   // ---------------- outputs ----------------
   logic owns, acc_ok;
   assign owns = (state == ARB_OWN) || (state == ARB_ACC);

   assign acc_ok = (state == ARB_ACC)
                || (state == ARB_OWN && !master_mode && !slave_yield)
                || ((state == ARB_IDLE || state == ARB_WAIT) && master_mode && bus_free);

   assign req_out    = br_q;
   assign req_oe     = master_mode;
   assign gnt_out    = (state == ARB_REL);
   assign gnt_oe     = !master_mode;
   assign busy_out   = owns;
   assign strobe_oe  = {NUM_STROBES{owns}};
   assign wait_st    = core_req && !acc_ok;
   assign acc_active = (state == ARB_ACC);
   assign acc_done   = last_ph;

   // ---------------- assertions ----------------
   a_r2_grant_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gnt_out) |-> $past(br_s));

   a_r5_rmw_blocks_release: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ARB_OWN && core_rmw) |=> (state != ARB_REL));

   a_r6_stay_released: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ARB_REL && (br_s || bb_s)) |=> gnt_out);

   a_r7_phase_advance: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_active && !acc_done) |=> (acc_active && acc_phase == PHASE_W'($past(acc_phase) + 1'b1)));

   a_r9_start_needs_grant: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(acc_active) && $past(master_mode)) |-> $past(bg_s && !bb_s));

   a_r11_program_toggle: assert property (@(posedge clk) disable iff (!rst_n)
      (master_mode && acc_done && prog_q && !req_hold && !core_rmw) |=> !req_out);

   a_r12_slave_no_req: assert property (@(posedge clk) disable iff (!rst_n)
      (!master_mode && !$past(master_mode)) |-> !req_out);
endmodule

// File: tb/busarb_ctrl_test.sv
`timescale 1ns/1ps
module busarb_ctrl_test;
   localparam int CLK_PERIOD = 10;
   localparam int NPH = 4;
   localparam int NSTB = 5;
   localparam int S_OWN = 0, S_REL = 1, S_IDLE = 2, S_WAIT = 3, S_ACC = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic master_mode = 1'b0, req_hold = 1'b0, core_req = 1'b0, core_prog = 1'b0, core_rmw = 1'b0;
   logic req_in = 1'b0, gnt_in = 1'b0, busy_in = 1'b0;
   logic req_out, req_oe, gnt_out, gnt_oe, busy_out, wait_st, acc_active, acc_done;
   logic [NSTB-1:0] strobe_oe;
   logic [1:0] acc_phase;

   int n_checks = 0;
   int n_err = 0;
   bit cmp_en = 1'b0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   busarb_ctrl #(.NUM_PHASES(NPH), .SYNC_STAGES(2), .NUM_STROBES(NSTB)) uut (
      .clk(clk), .rst_n(rst_n), .master_mode(master_mode), .req_hold(req_hold),
      .core_req(core_req), .core_prog(core_prog), .core_rmw(core_rmw),
      .req_in(req_in), .req_out(req_out), .req_oe(req_oe),
      .gnt_in(gnt_in), .gnt_out(gnt_out), .gnt_oe(gnt_oe),
      .busy_in(busy_in), .busy_out(busy_out), .strobe_oe(strobe_oe),
      .wait_st(wait_st), .acc_active(acc_active), .acc_phase(acc_phase), .acc_done(acc_done)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // ---------------- reference model from the requirements ----------------
   int m_st, m_ph;
   logic m_br, m_prog;
   logic [2:0] m_s1, m_s2;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_st = S_OWN; m_ph = 0; m_br = 0; m_prog = 0; m_s1 = 0; m_s2 = 0;
      end else begin
         logic rq, fr, last;
         int nst;
         rq   = m_s2[0];
         fr   = m_s2[1] && !m_s2[2];
         last = (m_st == S_ACC) && (m_ph == NPH-1);
         nst  = m_st;
         case (m_st)
            S_OWN:  if (master_mode) nst = S_IDLE;
                    else if (rq && !core_rmw) nst = S_REL;
                    else if (core_req) nst = S_ACC;
            S_REL:  if (!rq && !m_s2[2]) nst = S_OWN;
            S_IDLE: if (!master_mode) nst = S_OWN;
                    else if (core_req) nst = fr ? S_ACC : S_WAIT;
            S_WAIT: if (!master_mode) nst = S_OWN;
                    else if (fr) nst = S_ACC;
            default: if (last) nst = master_mode ? S_IDLE : S_OWN;
         endcase
         if (!master_mode) m_br = 0;
         else if (m_st == S_ACC) m_br = last ? (req_hold || core_rmw || !m_prog) : 1'b1;
         else m_br = req_hold || core_rmw || core_req;
         if (m_st != S_ACC && nst == S_ACC) m_prog = core_prog;
         m_ph = (m_st == S_ACC && !last) ? m_ph + 1 : 0;
         m_st = nst;
         m_s2 = m_s1;
         m_s1 = {busy_in, gnt_in, req_in};
      end
   end

   task automatic compare_model();
      logic own, ok, fr;
      own = (m_st == S_OWN) || (m_st == S_ACC);
      fr  = m_s2[1] && !m_s2[2];
      ok  = (m_st == S_ACC) || (m_st == S_OWN && !master_mode && !(m_s2[0] && !core_rmw))
         || ((m_st == S_IDLE || m_st == S_WAIT) && master_mode && fr);
      chk("R12 req_out", req_out, m_br);
      chk("R3 gnt_out", gnt_out, m_st == S_REL);
      chk("R10 busy_out", busy_out, own);
      chk("R3 strobe_oe", strobe_oe, {NSTB{own}});
      chk("R8 wait_st", wait_st, core_req && !ok);
      chk("R7 acc_active", acc_active, m_st == S_ACC);
      chk("R7 acc_done", acc_done, (m_st == S_ACC) && (m_ph == NPH-1));
      if (m_st == S_ACC) chk("R7 acc_phase", acc_phase, m_ph);
   endtask

   always begin
      @(posedge clk); #2;
      if (cmp_en) compare_model();
   end

   task automatic step();
      @(posedge clk); #2;
   endtask

   task automatic do_reset(input logic mode);
      @(negedge clk);
      rst_n = 0; master_mode = mode; req_hold = 0; core_req = 0; core_prog = 0; core_rmw = 0;
      req_in = 0; gnt_in = mode; busy_in = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
   endtask

   task automatic report();
      if (!finished) begin
         finished = 1'b1;
         $display("Result: errors=%0d of %0d checks", n_err, n_checks);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_checks++; n_err++;
      $display("FAIL watchdog expired");
      report();
   end

   initial begin
      void'($urandom(32'h1DEA5EED));
      // ---------- reset state (R1) ----------
      repeat (2) @(negedge clk);
      step();
      chk("R1 busy_out", busy_out, 1); chk("R1 strobe_oe", strobe_oe, {NSTB{1'b1}});
      chk("R1 gnt_out", gnt_out, 0); chk("R1 req_out", req_out, 0);
      chk("R1 wait_st", wait_st, 0); chk("R1 req_oe", req_oe, 0); chk("R1 gnt_oe", gnt_oe, 1);
      @(negedge clk); rst_n = 1;
      cmp_en = 1;
      repeat (2) step();

      // ---------- slave grant latency (R2, R3) ----------
      @(negedge clk); req_in = 1; busy_in = 1;
      step(); step(); chk("R2 gnt not yet", gnt_out, 0);
      step(); chk("R2 gnt third edge", gnt_out, 1);
      chk("R3 busy released", busy_out, 0); chk("R3 strobes off", strobe_oe, 0);
      @(negedge clk); core_req = 1; core_prog = 0;
      step(); chk("R8 wait while released", wait_st, 1);
      // ---------- return needs both low (R6) ----------
      @(negedge clk); req_in = 0;
      repeat (4) step(); chk("R6 busy still high", gnt_out, 1);
      @(negedge clk); busy_in = 0;
      step(); step(); chk("R6 not yet back", gnt_out, 1);
      step(); chk("R6 regained gnt", gnt_out, 0); chk("R6 regained busy", busy_out, 1);
      chk("R8 no wait when owned", wait_st, 0);
      step(); chk("R7 phase0", acc_active, 1); chk("R7 phase0 index", acc_phase, 0);
      step(); step(); step(); chk("R7 last phase", acc_done, 1); chk("R7 phase3", acc_phase, 3);
      @(negedge clk); core_req = 0;
      step();

      // ---------- request mid-access (R4) ----------
      @(negedge clk); core_req = 1; core_prog = 1;
      step(); chk("R4 access started", acc_phase, 0);
      @(negedge clk); req_in = 1;
      step(); step(); chk("R4 no grant in ph2", gnt_out, 0);
      step(); chk("R4 ph3 done", acc_done, 1); chk("R4 no grant in ph3", gnt_out, 0);
      @(negedge clk); core_req = 0;
      step(); chk("R4 boundary owned", busy_out, 1); chk("R4 no grant at boundary", gnt_out, 0);
      step(); chk("R4 grant after access", gnt_out, 1);
      @(negedge clk); req_in = 0;
      step(); step(); step(); chk("R6 back after req drop", gnt_out, 0);

      // ---------- read-modify-write lock (R5) ----------
      @(negedge clk); core_rmw = 1; req_in = 1;
      repeat (5) step(); chk("R5 no release under lock", gnt_out, 0);
      @(negedge clk); core_rmw = 0;
      step(); chk("R5 release after lock", gnt_out, 1);
      @(negedge clk); req_in = 0;
      repeat (4) step(); chk("R6 owned again", busy_out, 1);

      // ---------- master mode, grant tied high ----------
      do_reset(1);
      repeat (4) step();
      chk("R1 req_oe master", req_oe, 1); chk("R1 gnt_oe master", gnt_oe, 0);
      chk("R10 not owner idle", busy_out, 0); chk("R10 strobes off idle", strobe_oe, 0);
      chk("R12 req low idle", req_out, 0);
      @(negedge clk); core_req = 1; core_prog = 1;
      step(); chk("R13 req with phase0", req_out, 1); chk("R13 phase0", acc_active, 1);
      chk("R10 owner in access", busy_out, 1);
      step(); step(); step(); chk("R7 master done", acc_done, 1);
      @(negedge clk); core_req = 0;
      step(); chk("R11 program toggles req", req_out, 0); chk("R10 released after", busy_out, 0);
      @(negedge clk); core_req = 1; core_prog = 0;
      step(); step(); step(); step(); chk("R7 data done", acc_done, 1);
      @(negedge clk); core_req = 0;
      step(); chk("R11 data keeps req", req_out, 1);
      step(); chk("R11 req drops when idle", req_out, 0);
      @(negedge clk); req_hold = 1;
      step(); chk("R12 hold forces req", req_out, 1);
      @(negedge clk); req_hold = 0;
      step(); chk("R12 hold off", req_out, 0);

      // ---------- master waits for grant (R9) ----------
      @(negedge clk); gnt_in = 0;
      repeat (3) step();
      @(negedge clk); core_req = 1; core_prog = 0;
      step(); chk("R9 req raised", req_out, 1); chk("R9 not started", acc_active, 0);
      chk("R8 wait no grant", wait_st, 1);
      step(); step(); chk("R9 still waiting", acc_active, 0); chk("R9 req held", req_out, 1);
      @(negedge clk); gnt_in = 1;
      step(); step(); chk("R9 sync delay", acc_active, 0);
      step(); chk("R9 started", acc_active, 1); chk("R9 phase0", acc_phase, 0);
      step(); step(); step();
      @(negedge clk); core_req = 0;
      step();

      // ---------- constrained random against the model ----------
      for (int mode = 0; mode < 2; mode++) begin
         do_reset(logic'(mode));
         for (int cyc = 0; cyc < 3000; cyc++) begin
            @(negedge clk);
            if (!core_req) begin
               if ($urandom_range(2) == 0) begin core_req = 1; core_prog = logic'($urandom_range(1)); end
            end else if (acc_done) begin
               core_req = ($urandom_range(1) == 0); core_prog = logic'($urandom_range(1));
            end
            if ($urandom_range(15) == 0) core_rmw = ~core_rmw;
            if ($urandom_range(15) == 0) req_hold = ~req_hold;
            if ($urandom_range(7) == 0) req_in = ~req_in;
            if ($urandom_range(7) == 0) gnt_in = ~gnt_in;
            if ($urandom_range(9) == 0) busy_in = ~busy_in;
         end
      end
      step();
      cmp_en = 0;
      report();
   end
endmodule